// File: doc/BRIEF.md
# Real-Time Clock Interrupt and Clock-Out Pin Controller

This block drives the one active-low output pin that a real-time clock shares between a programmable square-wave output and an alarm interrupt. A single 8-bit control register selects everything. Its low nibble picks one of fifteen output frequencies, from the timebase itself down to one cycle every 32 seconds, or turns the square wave off. The upper bits hold the alarm enable, the alarm style (one pulse per match, or a level that stays until software acknowledges it), a stored-only low-power flag, and a switch that silences the pin while the chip runs from its backup battery.

The block runs on the timebase clock, whose frequency is 2^TB_LOG2 Hz. An external comparator supplies a one-cycle alarm-match pulse, and a supply monitor supplies the battery-mode level. The host writes the control register or the alarm status flag through a small synchronous write port, and reads both back on dedicated outputs. When a nonzero frequency code is in force, the square wave owns the pin and the alarm never touches it. The alarm status flag still records every match.

Top module: `rtc_irq_pin_ctrl`

## Requirements
- R1: After reset the control readback is 0x00, the alarm flag is 0 and pin_n is 1.
- R2: A write with wr_en=1 and wr_sel=0 loads wr_data into the control register, visible on ctrl_rd after that edge. The bit fields are: bit 7 alarm style (1 = pulsed, 0 = latched), bit 6 alarm enable, bit 5 low-power flag (stored only, no effect on the pin), bit 4 battery silence, and bits 3:0 frequency code.
- R3: Codes map to frequencies as follows: 1→32768 Hz, 2→4096 Hz, 3→1024 Hz, and code c in 4..15 → 2^(10−c) Hz. A code whose frequency f is below the timebase gives a 50%-duty square wave with a period of 2^TB_LOG2/f cycles. A code whose f is at or above the timebase passes the timebase clock through (high while the clock is high). Code 0 turns the square wave off.
- R4: A new frequency code takes effect only once the pin is high. A low phase already under way always runs its full half period. After the switch, the new wave starts from the start of its high half.
- R5: While the frequency code is nonzero, alarm matches have no effect on pin_n.
- R6: With alarm enable at 0, alarm matches have no effect on pin_n.
- R7: In pulsed style, each match drives pin_n low for exactly 2^TB_LOG2/4 cycles (250 ms), beginning on the edge that samples the match. Every match repeats the pulse.
- R8: In latched style, pin_n is low while the alarm flag is 1 and returns high on the edge that clears the flag.
- R9: Every match sets the alarm flag, whatever the mode. A write with wr_sel=1 and wr_data[0]=0 clears it. wr_data[0]=1 leaves it unchanged. A match in the same cycle as a clear leaves the flag set.
- R10: With battery silence at 1 and bat_mode at 1, pin_n is held at 1 for both the square wave and the alarm. With battery silence at 0, the pin keeps working in battery mode.
- R11: With no square wave and no active alarm, pin_n rests at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tb | input | 1 | Timebase clock, 2^TB_LOG2 Hz |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_match | input | 1 | One-cycle pulse from the alarm comparator |
| bat_mode | input | 1 | 1 while running from the backup battery |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 the alarm flag |
| wr_data | input | 8 | Host write data |
| ctrl_rd | output | 8 | Control register readback |
| alarm_flag | output | 1 | Alarm status flag |
| pin_n | output | 1 | Shared active-low interrupt / clock-out pin |

## Verification
Register writes and the alarm flag change on the edge that samples the strobe. A changed frequency code restarts the divider one edge later, unless a low phase is still running, in which case the restart waits for it to end. A pulsed alarm goes low on the sampling edge and stays low for exactly the pulse count. The latched pin follows the flag on the same edge. The battery gate acts combinationally. The bench drives inputs on falling edges and samples pin_n on falling edges into a run-length monitor. Half-period, low-width and pulse-width checks therefore compare whole measured runs with arithmetic expectations and never depend on a guessed start cycle. The pass-through codes are checked just after each edge of the clock.

// File: rtl/rtc_pin_pkg.sv
package rtc_pin_pkg;

    typedef struct packed {
        logic       irq_pulse;  // bit 7: 1 = pulsed alarm, 0 = latched alarm
        logic       alarm_en;   // bit 6
        logic       low_pwr;    // bit 5: stored only
        logic       bat_quiet;  // bit 4: silence pin in battery mode
        logic [3:0] fsel;       // bits 3:0: frequency code
    } pinctl_t;

    // log2 of the output frequency in Hz selected by a nonzero code
    function automatic int fsel_exp(input logic [3:0] code);
        case (code)
            4'd1:    return 15;
            4'd2:    return 12;
            4'd3:    return 10;
            default: return 10 - int'(code);
        endcase
    endfunction

endpackage

// File: rtl/rtc_pin_regs.sv
module rtc_pin_regs
    import rtc_pin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       match,
    output pinctl_t    ctrl,
    output logic       flag
);

    typedef struct packed {
        pinctl_t ctrl;
        logic    flag;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && !wr_sel) begin
            st_d.ctrl = pinctl_t'(wr_data);
        end
        if (wr_en && wr_sel && !wr_data[0]) begin
            st_d.flag = 1'b0;
        end
        if (match) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.ctrl;
    assign flag = st_q.flag;

    // R9
    match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag);

    // R9
    host_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && !wr_data[0] && !match) |=> !flag);

    // R2
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (ctrl == $past(wr_data)));

endmodule

// File: rtl/rtc_fout_div.sv
module rtc_fout_div
    import rtc_pin_pkg::*;
#(
    parameter int TB_LOG2 = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] fsel,
    output logic       fout_on,
    output logic       wave_n
);

    localparam int DIV_W = TB_LOG2 + 5;
    localparam int TAP_W = $clog2(DIV_W);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [3:0]       act;
    } div_t;

    div_t st_d, st_q;
    logic low_now;

    function automatic logic pass_thru(input logic [3:0] code);
        return (code != 4'd0) && (TB_LOG2 - fsel_exp(code) <= 0);
    endfunction

    function automatic logic [TAP_W-1:0] tap_of(input logic [3:0] code);
        int t;
        t = TB_LOG2 - fsel_exp(code) - 1;
        if (t < 0) t = 0;
        return TAP_W'(t);
    endfunction

    always_comb begin
        st_d    = st_q;
        low_now = (st_q.act != 4'd0) && !pass_thru(st_q.act)
                  && st_q.cnt[tap_of(st_q.act)];
        if ((fsel != st_q.act) && !low_now) begin
            st_d.act = fsel;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fout_on = (st_q.act != 4'd0);

    always_comb begin
        if (st_q.act == 4'd0)          wave_n = 1'b1;
        else if (pass_thru(st_q.act))  wave_n = clk;
        else                           wave_n = ~st_q.cnt[tap_of(st_q.act)];
    end

    // R4
    hold_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_now |=> (st_q.act == $past(st_q.act)));

    // R4
    restart_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsel != st_q.act) && !low_now) |=> (st_q.cnt == '0));

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq #(
    parameter int PULSE_CYC = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic armed,
    input  logic pulse_mode,
    input  logic flag,
    output logic irq_low
);

    localparam int TMR_W = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
    } alm_t;

    alm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!(armed && pulse_mode))  st_d.tmr = '0;
        else if (match)              st_d.tmr = TMR_W'(PULSE_CYC);
        else if (st_q.tmr != '0)     st_d.tmr = st_q.tmr - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_low = armed && (pulse_mode ? (st_q.tmr != '0) : flag);

    // R7
    pulse_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pulse_mode && match) |=> (st_q.tmr == TMR_W'(PULSE_CYC)));

    // R7
    pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && pulse_mode) |=> (st_q.tmr == '0));

endmodule

// File: rtl/rtc_irq_pin_ctrl.sv
module rtc_irq_pin_ctrl
    import rtc_pin_pkg::*;
#(
    parameter int TB_LOG2 = 15
) (
    input  logic       clk_tb,
    input  logic       rst_n,
    input  logic       alarm_match,
    input  logic       bat_mode,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] ctrl_rd,
    output logic       alarm_flag,
    output logic       pin_n
);

    localparam int PULSE_CYC = (2 ** TB_LOG2) / 4;

    pinctl_t ctrl;
    logic    flag;
    logic    fout_on;
    logic    wave_n;
    logic    armed;
    logic    irq_low;
    logic    silenced;

    rtc_pin_regs u_regs (
        .clk     (clk_tb),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .match   (alarm_match),
        .ctrl    (ctrl),
        .flag    (flag)
    );

    rtc_fout_div #(.TB_LOG2(TB_LOG2)) u_div (
        .clk     (clk_tb),
        .rst_n   (rst_n),
        .fsel    (ctrl.fsel),
        .fout_on (fout_on),
        .wave_n  (wave_n)
    );

    assign armed = ctrl.alarm_en && (ctrl.fsel == 4'd0);

    rtc_alarm_irq #(.PULSE_CYC(PULSE_CYC)) u_alarm (
        .clk        (clk_tb),
        .rst_n      (rst_n),
        .match      (alarm_match),
        .armed      (armed),
        .pulse_mode (ctrl.irq_pulse),
        .flag       (flag),
        .irq_low    (irq_low)
    );

    assign silenced = bat_mode && ctrl.bat_quiet;

    always_comb begin
        if (silenced)      pin_n = 1'b1;
        else if (fout_on)  pin_n = wave_n;
        else               pin_n = ~irq_low;
    end

    assign ctrl_rd    = ctrl;
    assign alarm_flag = flag;

    // R10
    battery_quiet_chk: assert property (@(posedge clk_tb) disable iff (!rst_n)
        (bat_mode && ctrl.bat_quiet) |-> pin_n);

    // R5
    fout_precedence_chk: assert property (@(posedge clk_tb) disable iff (!rst_n)
        (ctrl.fsel != 4'd0) |-> !irq_low);

    // R6
    alarm_disabled_chk: assert property (@(posedge clk_tb) disable iff (!rst_n)
        !ctrl.alarm_en |-> !irq_low);

endmodule

// File: tb/rtc_irq_pin_ctrl_test.sv
module rtc_irq_pin_ctrl_test;

    localparam int TBL = 9;
    localparam int PULSE = (2 ** TBL) / 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alarm_match = 1'b0;
    logic       bat_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] ctrl_rd;
    logic       alarm_flag;
    logic       pin_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // run-length monitor, sampled on falling edges
    int lows = 0, highs = 0, low_len = 0, high_len = 0, run = 0;
    logic lvl = 1'b1;

    always #2 clk = ~clk;

    rtc_irq_pin_ctrl #(.TB_LOG2(TBL)) uut (
        .clk_tb      (clk),
        .rst_n       (rst_n),
        .alarm_match (alarm_match),
        .bat_mode    (bat_mode),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .ctrl_rd     (ctrl_rd),
        .alarm_flag  (alarm_flag),
        .pin_n       (pin_n)
    );

    always @(negedge clk) begin
        if (pin_n !== lvl) begin
            if (lvl == 1'b0) begin low_len = run; lows = lows + 1; end
            else             begin high_len = run; highs = highs + 1; end
            lvl = pin_n;
            run = 1;
        end else begin
            run = run + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
    endtask

    task automatic fire();
        @(negedge clk);
        alarm_match = 1'b1;
        @(negedge clk);
        alarm_match = 1'b0;
    endtask

    task automatic wait_lows(input int target);
        while (lows < target) @(negedge clk);
    endtask

    function automatic int code_exp(input int c);
        if (c == 1) return 15;
        if (c == 2) return 12;
        if (c == 3) return 10;
        return 10 - c;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(ctrl_rd == 8'h00, "R1 ctrl", int'(ctrl_rd), 0);
        chk(alarm_flag == 1'b0, "R1 flag", int'(alarm_flag), 0);
        chk(pin_n == 1'b1, "R1 pin", int'(pin_n), 1);

        // R2 low-power flag stored only; R11 idle high
        n = lows;
        wr(1'b0, 8'h20);
        chk(ctrl_rd == 8'h20, "R2 readback", int'(ctrl_rd), 32);
        repeat (20) @(negedge clk);
        chk(lows == n && pin_n == 1'b1, "R11 idle pin", int'(pin_n), 1);

        // R3 pass-through codes
        for (int c = 1; c <= 3; c++) begin
            wr(1'b0, 8'(c));
            repeat (3) @(negedge clk);
            for (int k = 0; k < 4; k++) begin
                @(posedge clk); #1;
                chk(pin_n == 1'b1, "R3 passthru high", int'(pin_n), 1);
                @(negedge clk); #1;
                chk(pin_n == 1'b0, "R3 passthru low", int'(pin_n), 0);
            end
        end
        wr(1'b0, 8'h00);
        repeat (3) @(negedge clk);

        // R3 divided codes: half period 2^(TBL-e-1)
        for (int c = 4; c <= 15; c++) begin
            int h;
            h = 1 << (TBL - code_exp(c) - 1);
            wr(1'b0, 8'(c));
            n = lows;
            wait_lows(n + 2);
            chk(low_len == h, "R3 low half", low_len, h);
            chk(high_len == h, "R3 high half", high_len, h);
        end

        // R4 code change during low phase
        wr(1'b0, 8'h08);
        n = lows;
        wait_lows(n + 1);
        while (pin_n) @(negedge clk);
        repeat (10) @(negedge clk);
        wr(1'b0, 8'h04);
        n = lows;
        wait_lows(n + 1);
        chk(low_len == 64, "R4 old low kept", low_len, 64);
        wait_lows(n + 2);
        chk(low_len == 4, "R4 new low", low_len, 4);

        // R5 precedence: latched alarm enabled but code 4 owns pin
        wr(1'b0, 8'h44);
        fire();
        chk(alarm_flag == 1'b1, "R9 flag in fout mode", int'(alarm_flag), 1);
        n = lows;
        wait_lows(n + 2);
        chk(low_len == 4 && high_len == 4, "R5 wave unaffected", low_len, 4);
        // back to alarm: latched pin follows flag (R8)
        wr(1'b0, 8'h40);
        repeat (20) @(negedge clk);
        chk(pin_n == 1'b0, "R8 latched after fout", int'(pin_n), 0);
        wr(1'b1, 8'h00);
        chk(pin_n == 1'b1, "R8 released", int'(pin_n), 1);
        chk(alarm_flag == 1'b0, "R9 cleared", int'(alarm_flag), 0);

        // R6 alarm disabled
        wr(1'b0, 8'h80);
        n = lows;
        fire();
        repeat (200) @(negedge clk);
        chk(lows == n && pin_n == 1'b1, "R6 no pin effect", int'(pin_n), 1);
        chk(alarm_flag == 1'b1, "R9 set when disabled", int'(alarm_flag), 1);
        wr(1'b1, 8'h00);

        // R8 latched style
        wr(1'b0, 8'h40);
        fire();
        chk(pin_n == 1'b0, "R8 latch low", int'(pin_n), 0);
        repeat (300) @(negedge clk);
        chk(pin_n == 1'b0, "R8 latch held", int'(pin_n), 0);
        wr(1'b1, 8'h01);
        chk(alarm_flag == 1'b1, "R9 write one no effect", int'(alarm_flag), 1);
        chk(pin_n == 1'b0, "R8 still low", int'(pin_n), 0);
        wr(1'b1, 8'h00);
        chk(pin_n == 1'b1, "R8 cleared high", int'(pin_n), 1);

        // R9 match wins over simultaneous clear
        @(negedge clk);
        alarm_match = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        alarm_match = 1'b0; wr_en = 1'b0; wr_sel = 1'b0;
        chk(alarm_flag == 1'b1, "R9 match wins", int'(alarm_flag), 1);
        wr(1'b1, 8'h00);

        // R7 pulsed style, repeated
        wr(1'b0, 8'hC0);
        for (int k = 0; k < 2; k++) begin
            n = lows;
            fire();
            wait_lows(n + 1);
            chk(low_len == PULSE, "R7 pulse width", low_len, PULSE);
            repeat (20) @(negedge clk);
        end
        wr(1'b1, 8'h00);

        // R10 battery silence with square wave
        wr(1'b0, 8'h14);
        bat_mode = 1'b1;
        repeat (20) @(negedge clk);
        n = lows;
        repeat (40) @(negedge clk);
        chk(lows == n && pin_n == 1'b1, "R10 wave silenced", int'(pin_n), 1);
        wr(1'b0, 8'h04);
        n = lows;
        wait_lows(n + 2);
        chk(low_len == 4, "R10 wave in battery", low_len, 4);

        // R10 battery silence with latched alarm
        wr(1'b0, 8'h50);
        repeat (10) @(negedge clk);
        fire();
        repeat (5) @(negedge clk);
        chk(pin_n == 1'b1, "R10 alarm silenced", int'(pin_n), 1);
        bat_mode = 1'b0;
        #1;
        chk(pin_n == 1'b0, "R10 alarm returns", int'(pin_n), 0);
        wr(1'b1, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule